// File: doc/BRIEF.md
# Multi-Ratio Clock Output Divider Network

This block turns one fast source waveform into a family of divided clock outputs that stay phase-aligned. The source is one of three plain inputs: the oscillator waveform, or one of two reference waveforms when the oscillator path is bypassed. Every clock input is treated as a level that is sampled on the system clock `clk`. Both the rising and the falling transitions of the chosen source count as active edges. Each active edge moves one shared down-counting divider chain by one step.

The counter bits feed a double-rate output, five identical base-rate outputs, one inverted base-rate output and a half-rate output. A rate control picks whether the chain's taps start at its lowest bit (no pre-divide) or one bit higher (pre-divide by two). A polarity control flips all outputs, which moves the aligned edges from rising to falling. Both controls are taken up only when the divider wraps, so an output never shows a runt pulse.

An active-low enable/reset input clears the divider and drops the output enable without waiting for a clock. The release of that input passes through a short synchroniser before the divider starts counting.

Top module: `clk_fanout_divider`

## Requirements
- R1: In bypass (`osc_path_i` = 0), `ref_pick_i` = 0 makes `ref0_i` the source and `ref_pick_i` = 1 makes `ref1_i` the source. Activity on the reference that is not picked moves no output.
- R2: With `osc_path_i` = 1 the source is `osc_i` and both references are ignored. With `osc_path_i` = 0 the source is the picked reference.
- R3: Every source level change (rising or falling) that is sampled on a `clk` rising edge while the divider runs counts as exactly one active edge. With no pre-divide, `dbl_o` changes on every such edge.
- R4: The number of active edges between changes of each output is set by `full_rate_i`. With `full_rate_i` = 1, `dbl_o` changes every 1 edge, the base outputs every 2 and `half_o` every 4. With `full_rate_i` = 0 those counts are 2, 4 and 8.
- R5: With polarity 0, every rising edge of a base output coincides with a rising edge of `dbl_o`, and every rising edge of `half_o` coincides with a rising edge of the base outputs.
- R6: With polarity 1 (`fall_align_i` = 1) all outputs are inverted, so the falling edges coincide in the same way instead.
- R7: The five `base_o` bits are always equal, and `base_n_o` is always their complement, including straight after reset.
- R8: While `oe_rst_n` = 0, `out_en_o` is 0 at once, without a clock edge. The divider is cleared, so every output rests at its idle level: `dbl_o`, `base_o` and `half_o` equal the applied polarity and `base_n_o` is its inverse.
- R9: After `oe_rst_n` rises, the divider starts counting on the third rising edge of `clk`. The first active edge after that makes the aligned transition on all outputs, from the cleared (all-zero) divider state.
- R10: A new value on `full_rate_i` or `fall_align_i` takes effect only on the active edge that wraps the divider, or while the divider is held in reset. With no active edge, a control change leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| oe_rst_n | input | 1 | Active-low asynchronous divider clear and output disable |
| osc_i | input | 1 | Oscillator waveform (sampled level) |
| ref0_i | input | 1 | Reference waveform 0 (sampled level) |
| ref1_i | input | 1 | Reference waveform 1 (sampled level) |
| ref_pick_i | input | 1 | 0 picks reference 0, 1 picks reference 1 |
| osc_path_i | input | 1 | 1 uses the oscillator, 0 bypasses to the picked reference |
| full_rate_i | input | 1 | 1 means no pre-divide, 0 means pre-divide by two |
| fall_align_i | input | 1 | 0 aligns rising edges, 1 inverts outputs to align falling edges |
| out_en_o | output | 1 | Output enable; 0 means the clock outputs are high impedance |
| dbl_o | output | 1 | Double-rate output |
| base_o | output | NUM_BASE | Base-rate outputs, all in phase |
| base_n_o | output | 1 | Base-rate output in opposite phase |
| half_o | output | 1 | Half-rate output |

## Verification
The hardest case to reach from the ports is a control change that arrives in the middle of a divider cycle while no active edge comes in. Only then can the deferred pickup of the rate and polarity controls be told apart from an immediate one. The bench tracks the divider phase in its own model. It stops the source waveform when that phase is not at the wrap point, flips both controls, and checks that the outputs stay frozen. It then restarts the source and lets the model confirm that the new settings appear exactly at the next wrap.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    // Number of divided tiers (double, base, half) and the counter that feeds them.
    localparam int TIERS = 3;
    localparam int CNT_W = TIERS + 1;
    localparam int IDX_W = $clog2(CNT_W);

    typedef struct packed {
        logic full_rate;
        logic fall_align;
    } ctl_t;

    typedef struct packed {
        logic dbl;
        logic base;
        logic half;
    } tap_t;

    // Pick the three tiers from the divider; the pre-divide shifts the taps up by one bit.
    function automatic tap_t pick_taps(input logic [CNT_W-1:0] cnt, input ctl_t c);
        tap_t t;
        logic [IDX_W-1:0] off;
        off    = c.full_rate ? IDX_W'(0) : IDX_W'(1);
        t.dbl  = cnt[off] ^ c.fall_align;
        t.base = cnt[off + IDX_W'(1)] ^ c.fall_align;
        t.half = cnt[off + IDX_W'(2)] ^ c.fall_align;
        return t;
    endfunction

endpackage

// File: rtl/cdiv_src_pick.sv
module cdiv_src_pick (
    input  logic clk,
    input  logic osc_i,
    input  logic ref0_i,
    input  logic ref1_i,
    input  logic ref_pick_i,
    input  logic osc_path_i,
    output logic step_o
);
    logic ref_lvl;
    logic src_lvl;
    logic src_prev;

    assign ref_lvl = ref_pick_i ? ref1_i : ref0_i;
    assign src_lvl = osc_path_i ? osc_i : ref_lvl;

    // Both transitions of the source are active edges.
    always_ff @(posedge clk) begin
        src_prev <= src_lvl;
    end

    assign step_o = src_lvl ^ src_prev;
endmodule

// File: rtl/cdiv_release.sv
module cdiv_release #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic run_o
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-2:0], 1'b1};
        end
    end

    assign run_o = sh_q[STAGES-1];
endmodule

// File: rtl/cdiv_chain.sv
module cdiv_chain
    import cdiv_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         run_i,
    input  logic         step_i,
    input  ctl_t         req_i,
    output logic [W-1:0] cnt_o,
    output ctl_t         ctl_o
);
    logic [W-1:0] cnt_q;
    ctl_t         ctl_q;
    logic         wrap;

    assign wrap = step_i && (cnt_q == '0);

    // Down counter: a bit rises only when every lower bit rises with it.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else if (run_i && step_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Controls are picked up in reset or on the wrapping edge only.
    always_ff @(posedge clk) begin
        if (!run_i || wrap) begin
            ctl_q <= req_i;
        end
    end

    assign cnt_o = cnt_q;
    assign ctl_o = ctl_q;
endmodule

// File: rtl/clk_fanout_divider.sv
module clk_fanout_divider
    import cdiv_pkg::*;
#(
    parameter int NUM_BASE    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                oe_rst_n,
    input  logic                osc_i,
    input  logic                ref0_i,
    input  logic                ref1_i,
    input  logic                ref_pick_i,
    input  logic                osc_path_i,
    input  logic                full_rate_i,
    input  logic                fall_align_i,
    output logic                out_en_o,
    output logic                dbl_o,
    output logic [NUM_BASE-1:0] base_o,
    output logic                base_n_o,
    output logic                half_o
);
    logic             src_step;
    logic             run;
    ctl_t             req;
    ctl_t             ctl_q;
    logic [CNT_W-1:0] cnt_q;
    tap_t             taps;
    logic             pol_applied;
    logic             rate_applied;

    assign req.full_rate  = full_rate_i;
    assign req.fall_align = fall_align_i;

    cdiv_src_pick u_src (
        .clk        (clk),
        .osc_i      (osc_i),
        .ref0_i     (ref0_i),
        .ref1_i     (ref1_i),
        .ref_pick_i (ref_pick_i),
        .osc_path_i (osc_path_i),
        .step_o     (src_step)
    );

    cdiv_release #(.STAGES(SYNC_STAGES)) u_rel (
        .clk    (clk),
        .arst_n (oe_rst_n),
        .run_o  (run)
    );

    cdiv_chain #(.W(CNT_W)) u_chain (
        .clk    (clk),
        .arst_n (oe_rst_n),
        .run_i  (run),
        .step_i (src_step),
        .req_i  (req),
        .cnt_o  (cnt_q),
        .ctl_o  (ctl_q)
    );

    assign taps         = pick_taps(cnt_q, ctl_q);
    assign pol_applied  = ctl_q.fall_align;
    assign rate_applied = ctl_q.full_rate;

    // The enable follows the reset pin directly, with no clock in the path.
    assign out_en_o = oe_rst_n;
    assign dbl_o    = taps.dbl;
    assign half_o   = taps.half;
    assign base_n_o = ~taps.base;

    for (genvar i = 0; i < NUM_BASE; i++) begin : g_base
        assign base_o[i] = taps.base;
    end
endmodule

// File: rtl/cdiv_checks.sv
module cdiv_checks #(
    parameter int NUM_BASE = 5
) (
    input logic                clk,
    input logic                oe_rst_n,
    input logic                run,
    input logic                step,
    input logic                pol_app,
    input logic                rate_app,
    input logic                fall_align_i,
    input logic                dbl_o,
    input logic [NUM_BASE-1:0] base_o,
    input logic                base_n_o,
    input logic                half_o
);
    // R7: the base copies never disagree
    a_r7_uniform: assert property (@(posedge clk) disable iff (!oe_rst_n)
        ($countones(base_o) == 0) || ($countones(base_o) == NUM_BASE));

    // R7: the inverted sibling is opposite the base outputs
    a_r7_opposite: assert property (@(posedge clk) disable iff (!oe_rst_n)
        base_n_o != base_o[0]);

    // R5 / R6: a slower output moves only together with the next faster one
    a_r5_half_nested: assert property (@(posedge clk) disable iff (!oe_rst_n)
        $changed(half_o) |-> $changed(base_o[0]));

    a_r5_base_nested: assert property (@(posedge clk) disable iff (!oe_rst_n)
        $changed(base_o[0]) |-> $changed(dbl_o));

    // R3: without pre-divide every active edge moves the double-rate output
    a_r3_every_edge: assert property (@(posedge clk) disable iff (!oe_rst_n)
        (run && step && rate_app && (pol_app == fall_align_i)) |=> $changed(dbl_o));

    // R10: no active edge, no output movement, whatever the controls do
    a_r10_hold_without_edge: assert property (@(posedge clk) disable iff (!oe_rst_n)
        (run && !step) |=> ($stable(dbl_o) && $stable(half_o) && $stable(base_o)));

    // R9: the synchroniser holds the divider for the first cycle after release
    a_r9_sync_hold: assert property (@(posedge clk) disable iff (!oe_rst_n)
        ($rose(oe_rst_n) && $stable(fall_align_i)) |=> $stable(dbl_o));

    // R8: in reset every output rests at the same idle level
    a_r8_idle_level: assert property (@(posedge clk)
        !oe_rst_n |-> ((dbl_o == half_o) && (base_o[0] == dbl_o)));
endmodule

bind clk_fanout_divider cdiv_checks #(.NUM_BASE(NUM_BASE)) u_checks (
    .clk          (clk),
    .oe_rst_n     (oe_rst_n),
    .run          (run),
    .step         (src_step),
    .pol_app      (pol_applied),
    .rate_app     (rate_applied),
    .fall_align_i (fall_align_i),
    .dbl_o        (dbl_o),
    .base_o       (base_o),
    .base_n_o     (base_n_o),
    .half_o       (half_o)
);

// File: tb/tb_clk_fanout_divider.sv
`timescale 1ns/100ps
module tb_clk_fanout_divider;
    localparam int NB = 5;

    logic clk = 1'b0;
    logic oe_rst_n = 1'b0;
    logic osc = 1'b0, r0 = 1'b0, r1 = 1'b0;
    logic ref_pick = 1'b0, osc_path = 1'b1, full_rate = 1'b1, fall = 1'b0;
    logic out_en, dbl, base_n, half;
    logic [NB-1:0] base;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    bit osc_run = 1, r0_run = 1, r1_run = 1;

    clk_fanout_divider #(.NUM_BASE(NB), .SYNC_STAGES(2)) dut (
        .clk(clk), .oe_rst_n(oe_rst_n), .osc_i(osc), .ref0_i(r0), .ref1_i(r1),
        .ref_pick_i(ref_pick), .osc_path_i(osc_path), .full_rate_i(full_rate),
        .fall_align_i(fall), .out_en_o(out_en), .dbl_o(dbl), .base_o(base),
        .base_n_o(base_n), .half_o(half)
    );

    initial forever #2.5 clk = ~clk;

    // Source waveforms with distinct periods
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            c++;
            if (osc_run && (c % 2 == 0)) osc = ~osc;
            if (r0_run && (c % 3 == 0)) r0 = ~r0;
            if (r1_run && (c % 5 == 0)) r1 = ~r1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model: phase = active edges since release, modulo 16
    bit m_prev = 0, m_rate = 1, m_pol = 0, m_edge = 0;
    int m_rel = 0, m_p = 0;

    function automatic bit lvl(input int p, input int h);
        int m;
        m = p % (2 * h);
        return (m >= 1) && (m <= h);
    endfunction

    always @(negedge oe_rst_n) begin
        m_rel = 0;
        m_p = 0;
    end

    always @(posedge clk) begin
        bit sel, runb;
        sel = osc_path ? osc : (ref_pick ? r1 : r0);
        runb = (m_rel >= 2);
        m_edge = runb && (sel != m_prev);
        if (!runb) begin
            m_rate = full_rate;
            m_pol = fall;
        end else if (m_edge) begin
            if (m_p == 0) begin
                m_rate = full_rate;
                m_pol = fall;
            end
            m_p = (m_p + 1) % 16;
        end
        m_prev = sel;
        if (oe_rst_n) begin
            if (m_rel < 2) m_rel++;
        end else begin
            m_rel = 0;
            m_p = 0;
        end
    end

    // Per-cycle comparison and edge-coincidence bookkeeping
    bit pd = 0, pb = 0, ph = 0, pn = 1, pen = 0;
    int viol_r5 = 0, seen_r5 = 0, viol_r6 = 0, seen_r6 = 0, viol_r7 = 0;
    bit r3_win = 0, tog_win = 0;
    int r3_edges = 0, r3_tog = 0, n_tog = 0;

    always @(negedge clk) begin
        bit e_dbl, e_base, e_half;
        if (!done) begin
            e_dbl  = lvl(m_p, m_rate ? 1 : 2) ^ m_pol;
            e_base = lvl(m_p, m_rate ? 2 : 4) ^ m_pol;
            e_half = lvl(m_p, m_rate ? 4 : 8) ^ m_pol;
            chk(out_en === oe_rst_n, "R8 enable", int'(out_en), int'(oe_rst_n));
            chk(dbl === e_dbl, "R4 R9 double-rate", int'(dbl), int'(e_dbl));
            chk(base === {NB{e_base}}, "R4 R7 base", int'(base), int'({NB{e_base}}));
            chk(half === e_half, "R4 half-rate", int'(half), int'(e_half));
            chk(base_n === ~e_base, "R7 inverted", int'(base_n), int'(~e_base));
            if (oe_rst_n && pen) begin
                if (!m_pol) begin
                    if (base[0] && !pb) seen_r5++;
                    if ((base[0] && !pb) && !(dbl && !pd)) viol_r5++;
                    if ((half && !ph) && !(base[0] && !pb)) viol_r5++;
                end else begin
                    if (!base[0] && pb) seen_r6++;
                    if ((!base[0] && pb) && !(!dbl && pd)) viol_r6++;
                    if ((!half && ph) && !(!base[0] && pb)) viol_r6++;
                end
                if ((base[0] && !pb) && !(!base_n && pn)) viol_r7++;
            end
            if (r3_win) begin
                if (m_edge) r3_edges++;
                if (dbl != pd) r3_tog++;
            end
            if (tog_win && (dbl != pd)) n_tog++;
            pd = dbl; pb = base[0]; ph = half; pn = base_n; pen = oe_rst_n;
        end
    end

    task automatic step_cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        bit hd, hh;
        logic [NB-1:0] hb;
        step_cycles(3);
        // R8: reset state
        chk(out_en == 1'b0, "R8 reset enable", int'(out_en), 0);
        chk(dbl == 1'b0 && half == 1'b0 && base == '0 && base_n == 1'b1,
            "R8 R7 reset idle", int'({dbl, half, base_n}), 1);
        oe_rst_n = 1'b1;
        // R9: two cycles of synchroniser hold
        step_cycles(1);
        chk(dbl == 1'b0, "R9 hold cycle 1", int'(dbl), 0);
        step_cycles(1);
        chk(dbl == 1'b0, "R9 hold cycle 2", int'(dbl), 0);

        // Every combination of source path, rate and polarity
        for (int b = 0; b < 2; b++) begin
            for (int r = 0; r < 2; r++) begin
                for (int q = 0; q < 2; q++) begin
                    osc_path = b[0];
                    ref_pick = r[0] ^ q[0];
                    full_rate = r[0];
                    fall = q[0];
                    step_cycles(140);
                end
            end
        end
        chk(viol_r5 == 0 && seen_r5 > 0, "R5 rising coincidence", viol_r5, 0);
        chk(viol_r6 == 0 && seen_r6 > 0, "R6 falling coincidence", viol_r6, 0);
        chk(viol_r7 == 0, "R7 opposite phase", viol_r7, 0);

        // R3: one double-rate change per active edge
        osc_path = 1; full_rate = 1; fall = 0;
        step_cycles(60);
        r3_win = 1;
        step_cycles(64);
        r3_win = 0;
        chk(r3_tog == r3_edges && r3_edges > 0, "R3 edge count", r3_tog, r3_edges);

        // R1: reference pick
        osc_path = 0; ref_pick = 1; r0_run = 0; r1_run = 1;
        step_cycles(4);
        n_tog = 0; tog_win = 1; step_cycles(40); tog_win = 0;
        chk(n_tog > 0, "R1 ref1 drives", n_tog, 1);
        ref_pick = 0;
        step_cycles(3);
        n_tog = 0; tog_win = 1; step_cycles(40); tog_win = 0;
        chk(n_tog == 0, "R1 ref1 ignored", n_tog, 0);

        // R2: oscillator path ignores references
        r0_run = 1; osc_run = 0; osc_path = 1;
        step_cycles(3);
        n_tog = 0; tog_win = 1; step_cycles(40); tog_win = 0;
        chk(n_tog == 0, "R2 refs ignored", n_tog, 0);
        osc_path = 0;
        step_cycles(3);
        n_tog = 0; tog_win = 1; step_cycles(40); tog_win = 0;
        chk(n_tog > 0, "R2 bypass drives", n_tog, 1);

        // R10: freeze the source away from the wrap point, then flip controls
        osc_path = 1; osc_run = 1;
        step_cycles(40);
        for (int k = 0; k < 20; k++) begin
            osc_run = 0;
            step_cycles(3);
            if (m_p % 16 != 0) break;
            osc_run = 1;
            step_cycles(1);
        end
        hd = dbl; hb = base; hh = half;
        fall = 1; full_rate = 0;
        step_cycles(6);
        chk(dbl == hd && base == hb && half == hh, "R10 deferred change",
            int'({dbl, half}), int'({hd, hh}));
        osc_run = 1;
        step_cycles(80);
        chk(m_pol == 1'b1 && m_rate == 1'b0, "R10 applied at wrap", int'({m_pol, m_rate}), 2);

        // R8: asynchronous clear in mid-run
        @(negedge clk); #1;
        oe_rst_n = 0;
        #1;
        chk(out_en == 1'b0, "R8 async disable", int'(out_en), 0);
        chk(dbl == m_pol && half == m_pol && base == {NB{m_pol}} && base_n == !m_pol,
            "R8 async idle", int'({dbl, half}), int'({m_pol, m_pol}));
        step_cycles(4);
        oe_rst_n = 1;
        hd = dbl;
        step_cycles(1);
        chk(dbl == hd, "R9 release hold 1", int'(dbl), int'(hd));
        step_cycles(1);
        chk(dbl == hd, "R9 release hold 2", int'(dbl), int'(hd));
        step_cycles(80);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule